// File: doc/BRIEF.md
# Memory Region Select Decoder

This block turns each address on a 16-bit bus shared by a processor and a video controller into active-low chip selects. The top three address bits pick one of eight 8 KB regions. The lowest region is split further. One select covers the on-board low RAM. Three 1 KB expansion-port selects cover the window the on-board RAM leaves empty, from $0400 to $0FFF. A bus-phase input tells processor cycles from video cycles. The expansion selects only appear in processor cycles, because the video controller cannot reach the expansion port.

A single control bit, written through a small write port, can hand the whole lowest region to an external memory device. While the bit is set, the lowest-region select, the on-board low-RAM select and the three expansion selects all stay idle. A dedicated takeover select is driven instead for processor cycles in $0000-$1FFF. While the bit is clear, the block works as a plain eight-way region decoder and the takeover select never asserts.

Reset is asynchronous and active-low. Its release is synchronised inside the block, and every select stays high until that release has passed through.

Top module: `mem_region_decoder`

## Requirements
- R1: For an address whose bits 15..13 hold a value k from 1 to 7, region select k is low and the other seven region selects are high. This holds in both phases and both modes.
- R2: With the control bit clear, region select 0 is low for every address in $0000-$1FFF, in both phases.
- R3: With the control bit clear, the low-RAM select is low for $0000-$03FF and $1000-$1FFF in both phases, and high everywhere else.
- R4: With the control bit clear, in a processor cycle (phase input high), expansion select k (k = 0, 1, 2) is low exactly for $0400+k*$400 through $07FF+k*$400.
- R5: With the control bit set, the takeover select is low for every processor-cycle address in $0000-$1FFF. With the bit clear, it is never low.
- R6: With the control bit set, region select 0, the low-RAM select and all three expansion selects stay high for every address.
- R7: A write with the write strobe high loads the control bit from the write data at a rising clock edge. The new value governs decoding from the next cycle on. With the strobe low, the write data has no effect.
- R8: While reset is low, and for two clock edges after its release, every select is high. Reset clears the control bit.
- R9: In a processor cycle, outside reset, exactly one of these selects is low: region selects 1..7, low-RAM, the three expansion selects and the takeover select.
- R10: In a video cycle (phase input low), the expansion selects and the takeover select are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| cpu_phase_i | input | 1 | 1 = processor cycle, 0 = video cycle |
| mode_we_i | input | 1 | Control bit write strobe |
| mode_wdata_i | input | 1 | Control bit value, 1 = hand lowest region to external device |
| region_sel_n_o | output | 8 | Active-low 8 KB region selects, bit k for region k |
| lowram_sel_n_o | output | 1 | Active-low on-board low-RAM select |
| exp_sel_n_o | output | 3 | Active-low 1 KB expansion-port selects |
| redir_sel_n_o | output | 1 | Active-low takeover select to the external device |

## Verification
Two functions can land in the same cycle: a control-bit write and the decode of an address inside the lowest region. The bench provokes this by holding $0500 on the bus in a processor cycle while it raises the write strobe. The scoreboard expects the old routing, the expansion select, in the write cycle. In the cycle after it expects the new routing, the takeover select. Full sweeps in both modes and both phases then confirm that the routing stays consistent at every address.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int unsigned MRD_ADDR_W        = 16;
  localparam int unsigned MRD_REGION_BITS   = 3;
  localparam int unsigned MRD_PAGE_BITS     = 10;
  localparam int unsigned MRD_EXP_FIRST     = 1;
  localparam int unsigned MRD_EXP_PAGES     = 3;

  typedef enum logic {
    ROUTE_ONBOARD  = 1'b0,
    ROUTE_EXTERNAL = 1'b1
  } route_mode_e;
endpackage

// File: rtl/mrd_reset_sync.sv
module mrd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mrd_mode_reg.sv
module mrd_mode_reg
  import mrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_sync_n_i,
  input  logic        we_i,
  input  logic        wdata_i,
  output route_mode_e mode_o
);
  route_mode_e mode_q;
  route_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we_i) mode_d = route_mode_e'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n_i) begin
    if (!rst_sync_n_i) mode_q <= ROUTE_ONBOARD;
    else if (we_i)     mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R7: a strobed write lands on the next edge
  assert_mode_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n_i)
    we_i |=> (mode_q == route_mode_e'($past(wdata_i))));
  // R7: without the strobe the bit holds
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n_i)
    !we_i |=> $stable(mode_q));
endmodule

// File: rtl/mrd_region_decode.sv
module mrd_region_decode #(
  parameter int unsigned REGION_BITS = 3,
  localparam int unsigned NUM_REGIONS = 1 << REGION_BITS
) (
  input  logic [REGION_BITS-1:0] region_i,
  input  logic                   enable_i,
  input  logic                   suppress0_i,
  output logic [NUM_REGIONS-1:0] sel_n_o
);
  logic [NUM_REGIONS-1:0] hit;

  always_comb begin
    hit = '0;
    hit[region_i] = 1'b1;
  end

  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
    if (gi == 0) begin : g_low
      assign sel_n_o[gi] = ~(enable_i & hit[gi] & ~suppress0_i);
    end else begin : g_plain
      assign sel_n_o[gi] = ~(enable_i & hit[gi]);
    end
  end
endmodule

// File: rtl/mrd_low_decode.sv
module mrd_low_decode #(
  parameter int unsigned PAGE_IDX_W = 3,
  parameter int unsigned EXP_FIRST  = 1,
  parameter int unsigned EXP_PAGES  = 3
) (
  input  logic [PAGE_IDX_W-1:0] page_i,
  input  logic                  in_low_i,
  input  logic                  enable_i,
  input  logic                  external_i,
  input  logic                  cpu_phase_i,
  output logic                  lowram_sel_n_o,
  output logic [EXP_PAGES-1:0]  exp_sel_n_o,
  output logic                  redir_sel_n_o
);
  localparam int unsigned EXP_LAST = EXP_FIRST + EXP_PAGES - 1;

  logic in_exp;
  logic onboard_ok;

  always_comb begin
    in_exp     = (int'(page_i) >= int'(EXP_FIRST)) && (int'(page_i) <= int'(EXP_LAST));
    onboard_ok = enable_i & in_low_i & ~external_i;
  end

  assign lowram_sel_n_o = ~(onboard_ok & ~in_exp);
  assign redir_sel_n_o  = ~(enable_i & in_low_i & external_i & cpu_phase_i);

  for (genvar gk = 0; gk < EXP_PAGES; gk++) begin : g_exp
    assign exp_sel_n_o[gk] =
      ~(onboard_ok & cpu_phase_i & (page_i == PAGE_IDX_W'(EXP_FIRST + gk)));
  end
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mrd_pkg::*;
#(
  parameter int unsigned ADDR_W      = MRD_ADDR_W,
  parameter int unsigned REGION_BITS = MRD_REGION_BITS,
  parameter int unsigned PAGE_BITS   = MRD_PAGE_BITS,
  parameter int unsigned EXP_FIRST   = MRD_EXP_FIRST,
  parameter int unsigned EXP_PAGES   = MRD_EXP_PAGES,
  localparam int unsigned NUM_REGIONS = 1 << REGION_BITS,
  localparam int unsigned PAGE_IDX_W  = ADDR_W - REGION_BITS - PAGE_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   cpu_phase_i,
  input  logic                   mode_we_i,
  input  logic                   mode_wdata_i,
  output logic [NUM_REGIONS-1:0] region_sel_n_o,
  output logic                   lowram_sel_n_o,
  output logic [EXP_PAGES-1:0]   exp_sel_n_o,
  output logic                   redir_sel_n_o
);
  logic                   rst_ok;
  route_mode_e            mode;
  logic                   external;
  logic [REGION_BITS-1:0] region;
  logic [PAGE_IDX_W-1:0]  page;
  logic                   in_low;
  logic                   unused_addr_bits;

  assign region           = addr_i[ADDR_W-1 -: REGION_BITS];
  assign page             = addr_i[PAGE_BITS +: PAGE_IDX_W];
  assign in_low           = (region == '0);
  assign external         = (mode == ROUTE_EXTERNAL);
  assign unused_addr_bits = ^addr_i[PAGE_BITS-1:0];

  mrd_reset_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_sync_n_o (rst_ok)
  );

  mrd_mode_reg u_mode (
    .clk          (clk),
    .rst_sync_n_i (rst_ok),
    .we_i         (mode_we_i),
    .wdata_i      (mode_wdata_i),
    .mode_o       (mode)
  );

  mrd_region_decode #(.REGION_BITS(REGION_BITS)) u_region (
    .region_i    (region),
    .enable_i    (rst_ok),
    .suppress0_i (external),
    .sel_n_o     (region_sel_n_o)
  );

  mrd_low_decode #(
    .PAGE_IDX_W (PAGE_IDX_W),
    .EXP_FIRST  (EXP_FIRST),
    .EXP_PAGES  (EXP_PAGES)
  ) u_low (
    .page_i         (page),
    .in_low_i       (in_low),
    .enable_i       (rst_ok),
    .external_i     (external),
    .cpu_phase_i    (cpu_phase_i),
    .lowram_sel_n_o (lowram_sel_n_o),
    .exp_sel_n_o    (exp_sel_n_o),
    .redir_sel_n_o  (redir_sel_n_o)
  );

  // R1: upper regions decode to a single region select
  assert_region_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && !in_low) |-> (!region_sel_n_o[region] && ($countones(~region_sel_n_o) == 1)));
  // R2: lowest region select follows the address in onboard mode
  assert_low_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && in_low && !external) |-> !region_sel_n_o[0]);
  // R5: takeover select in processor cycles of the lowest region
  assert_takeover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && in_low && external && cpu_phase_i) |-> !redir_sel_n_o);
  // R6: external routing keeps all on-board low selects idle
  assert_suppress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    external |-> (region_sel_n_o[0] && lowram_sel_n_o && (&exp_sel_n_o)));
  // R8: nothing selected before the synchronised release
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> ((&region_sel_n_o) && lowram_sel_n_o && (&exp_sel_n_o) && redir_sel_n_o));
  // R9: one leaf select per processor cycle
  assert_single_leaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && cpu_phase_i) |->
      ($countones(~{region_sel_n_o[NUM_REGIONS-1:1], lowram_sel_n_o, exp_sel_n_o, redir_sel_n_o}) == 1));
  // R10: video cycles never reach expansion or external device
  assert_video_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_phase_i |-> ((&exp_sel_n_o) && redir_sel_n_o));
endmodule

// File: tb/mem_region_decoder_tb.sv
module mem_region_decoder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        phase;
  logic        we;
  logic        wd;
  logic [7:0]  region_n;
  logic        lowram_n;
  logic [2:0]  exp_n;
  logic        redir_n;

  int errors = 0;
  int checks = 0;
  logic mode_m = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [15:0] a;
    logic        ph;
    logic        rd;
    logic [12:0] expv;
  } item_t;
  item_t sb_q[$];

  mem_region_decoder dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_i         (addr),
    .cpu_phase_i    (phase),
    .mode_we_i      (we),
    .mode_wdata_i   (wd),
    .region_sel_n_o (region_n),
    .lowram_sel_n_o (lowram_n),
    .exp_sel_n_o    (exp_n),
    .redir_sel_n_o  (redir_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {takeover, exp[2:0], lowram, region[7:0]}, all active-low
  function automatic logic [12:0] model(input logic [15:0] a, input logic ph, input logic rd);
    logic [7:0] rg;
    logic [2:0] ex;
    logic       lr;
    logic       tk;
    logic       low;
    int         pg;
    rg  = 8'hFF;
    ex  = 3'b111;
    lr  = 1'b1;
    tk  = 1'b1;
    low = (a[15:13] == 3'd0);
    pg  = int'(a[12:10]);
    if (!low) rg[a[15:13]] = 1'b0;
    else if (rd) begin
      if (ph) tk = 1'b0;
    end else begin
      rg[0] = 1'b0;
      if (pg >= 1 && pg <= 3) begin
        if (ph) ex[pg-1] = 1'b0;
      end else lr = 1'b0;
    end
    return {tk, ex, lr, rg};
  endfunction

  function automatic logic [12:0] actual();
    return {redir_n, exp_n, lowram_n, region_n};
  endfunction

  task automatic apply(input logic [15:0] a, input logic ph);
    item_t it;
    @(negedge clk);
    addr = a; phase = ph; we = 1'b0;
    it.a = a; it.ph = ph; it.rd = mode_m; it.expv = model(a, ph, mode_m);
    sb_q.push_back(it);
  endtask

  // write the control bit while a lowest-region address is decoded
  task automatic write_mode(input logic [15:0] a, input logic val);
    item_t it;
    @(negedge clk);
    addr = a; phase = 1'b1; we = 1'b1; wd = val;
    it.a = a; it.ph = 1'b1; it.rd = mode_m; it.expv = model(a, 1'b1, mode_m);
    sb_q.push_back(it);
    @(negedge clk);
    we = 1'b0;
    mode_m = val;
    it.rd = val; it.expv = model(a, 1'b1, val);
    sb_q.push_back(it);
  endtask

  task automatic check_all_high(input string tag);
    checks++;
    if (actual() !== 13'h1FFF) begin
      errors++;
      $display("FAIL %s reset selects actual=%h expected=%h", tag, actual(), 13'h1FFF);
    end
  endtask

  // monitor: pops scoreboard items after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [12:0] act;
        logic [12:0] d;
        string tag;
        it  = sb_q.pop_front();
        act = actual();
        d   = act ^ it.expv;
        checks++;
        if (d != 13'd0) begin
          if (d[7:1] != 7'd0)      tag = "R1";
          else if (d[0])           tag = it.rd ? "R6" : "R2";
          else if (d[8])           tag = it.rd ? "R6" : "R3";
          else if (d[11:9] != 3'd0) tag = !it.ph ? "R10" : (it.rd ? "R6" : "R4");
          else                     tag = it.ph ? "R5" : "R10";
          errors++;
          $display("FAIL %s addr=%h phase=%0d mode=%0d actual=%h expected=%h",
                   tag, it.a, it.ph, it.rd, act, it.expv);
        end
        if (it.ph) begin
          int n;
          n = $countones(~{act[12:8], act[7:1]});
          checks++;
          if (n != 1) begin
            errors++;
            $display("FAIL R9 addr=%h leaf count actual=%0d expected=1", it.a, n);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 16'h0000; phase = 1'b1; we = 1'b0; wd = 1'b0;
    repeat (3) @(negedge clk);
    #4 check_all_high("R8");
    addr = 16'h0500; #1 check_all_high("R8");
    addr = 16'hE000; #1 check_all_high("R8");
    @(negedge clk) rst_n = 1'b1;
    #4 check_all_high("R8");
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4 R9 R10: onboard routing, both phases
    for (int i = 0; i < 65536; i += 4) apply(16'(i), 1'b1);
    for (int i = 0; i < 65536; i += 4) apply(16'(i), 1'b0);

    // boundary addresses of every sub-window
    apply(16'h03FF, 1'b1); apply(16'h0400, 1'b1); apply(16'h07FF, 1'b1);
    apply(16'h0800, 1'b1); apply(16'h0BFF, 1'b1); apply(16'h0C00, 1'b1);
    apply(16'h0FFF, 1'b1); apply(16'h1000, 1'b1); apply(16'h1FFF, 1'b1);
    apply(16'h2000, 1'b1); apply(16'hFFFF, 1'b1); apply(16'h0FFF, 1'b0);

    // R7: write data without strobe has no effect
    @(negedge clk); addr = 16'h0000; phase = 1'b1; wd = 1'b1; we = 1'b0;
    apply(16'h0000, 1'b1);
    apply(16'h0600, 1'b1);

    // R7 with R4/R5: write lands while an expansion address is decoded
    write_mode(16'h0500, 1'b1);

    // R5 R6 R9 R10: external routing, both phases
    for (int i = 0; i < 65536; i += 4) apply(16'(i), 1'b1);
    for (int i = 0; i < 65536; i += 4) apply(16'(i), 1'b0);
    apply(16'h1FFF, 1'b1); apply(16'h0401, 1'b1); apply(16'h2000, 1'b1);

    // R7: back to onboard
    write_mode(16'h0C00, 1'b0);
    apply(16'h0000, 1'b1);

    // R8: reset in external mode clears the control bit
    write_mode(16'h0100, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #4 check_all_high("R8");
    mode_m = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(16'h0100, 1'b1);
    apply(16'h0500, 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule